// File: doc/BRIEF.md
# Line Brownout Monitor

This block watches a digitized, rectified line voltage and decides whether the line is healthy enough for the converter to switch. It samples the line code on a fixed cadence, keeps the largest sample it sees across a group of sampling cycles, and publishes that maximum as the held line peak. At the start of each group the running maximum restarts from the group's first sample, so the held peak follows a falling line as well as a rising one. The cadence depends on load: it is faster at normal load and slower when the green-mode flag is set.

The held peak drives two things. The first is a line-OK flag with hysteresis. It asserts at once when the peak reaches the turn-on level. It drops only after the peak has stayed below the lower turn-off level for a debounce time counted in clock cycles. The second is a pair of threshold codes: a cycle-by-cycle current-limit level and an over-current trigger level. Both fall linearly as the line peak rises, so the converter's power limit stays about constant across the input range. The external comparators use these codes.

Line codes are in volts, 1 V per LSB. Threshold codes are in millivolts, 1 mV per LSB. The parameter defaults are 4 clock cycles per sample at normal load, 12 in green mode, 8 samples per group, and a 5-cycle turn-off debounce.

Top module: `line_brownout_monitor`

## Requirements
- R1: While reset is held and right after it is released, line_ok is 0, ilim_code is 825 and ocp_code is 480 (the held peak starts at 0).
- R2: A sample is taken every 4 clock cycles when green_mode is 0 and every 12 when it is 1. The held peak is republished once every 8 samples, which is every 32 or 96 cycles.
- R3: Each published peak is the maximum of the 8 samples taken in its group. A group with lower samples publishes a lower peak (the running maximum restarts at each group's first sample).
- R4: line_ok rises one clock cycle after a published peak of 114 or more while it is low. A peak of 113 leaves it low.
- R5: A published peak from 102 to 113 leaves line_ok unchanged, whether it is high or low.
- R6: While line_ok is high, a published peak below 102 clears line_ok exactly DEB_CYC (5) cycles after the publishing edge. A peak of 102 leaves it high.
- R7: For a held peak p in the range 122 to 366, ilim_code = 825 - floor((p-122)*100/244). It changes in the same cycle that the peak is published.
- R8: For a held peak p in the range 122 to 366, ocp_code = 480 - floor((p-122)*60/244).
- R9: A held peak at or below 122 gives ilim_code 825 and ocp_code 480. A peak at or above 366 gives 725 and 420.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_code | input | LINE_W (9) | Rectified line sample, 1 V per LSB |
| green_mode | input | 1 | Light-load flag that selects the slow sampling cadence |
| line_ok | output | 1 | Line is above brown-in and switching is allowed |
| ilim_code | output | TH_W (10) | Cycle-by-cycle current-limit threshold, mV |
| ocp_code | output | TH_W (10) | Over-current trigger threshold, mV |

## Verification
The assertions take the parameter set to be ordered: the turn-off level is below the turn-on level, the lower line corner is below the upper one, and each threshold falls from its low-line value to its high-line value. They also assume green_mode only changes the spacing between samples and never the contents of a group. They place no constraint on line_code, so they hold for any sample sequence. The stimulus holds line_code steady across whole groups, or moves it in slow ramps, and toggles green_mode only while the line is settled. As a result, every published peak the bench predicts depends only on the values it drove.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    typedef enum logic {
        CADENCE_FAST = 1'b0,
        CADENCE_SLOW = 1'b1
    } cadence_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int width_for(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/lbm_sample_timer.sv
module lbm_sample_timer
    import lbm_pkg::*;
#(
    parameter int SAMP_NORM = 4,
    parameter int SAMP_GREEN = 12,
    parameter int NSAMP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic stb_o,
    output logic first_o,
    output logic last_o
);
    localparam int MAXI = imax(SAMP_NORM, SAMP_GREEN);
    localparam int CW = width_for(MAXI);
    localparam int IW = width_for(NSAMP);
    localparam logic [CW-1:0] LIM_FAST = CW'(SAMP_NORM - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(SAMP_GREEN - 1);
    localparam logic [IW-1:0] IDX_END = IW'(NSAMP - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    cadence_e mode;
    logic [CW-1:0] limit;
    logic tick;

    always_comb begin
        mode = slow_i ? CADENCE_SLOW : CADENCE_FAST;
        case (mode)
            CADENCE_SLOW: limit = LIM_SLOW;
            default:      limit = LIM_FAST;
        endcase
        tick = (tmr_q.cnt >= limit);
        tmr_d = tmr_q;
        if (tick) begin
            tmr_d.cnt = '0;
            tmr_d.idx = (tmr_q.idx == IDX_END) ? '0 : tmr_q.idx + 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign stb_o   = tick;
    assign first_o = (tmr_q.idx == '0);
    assign last_o  = (tmr_q.idx == IDX_END);

    a_r2_idx_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.idx <= IDX_END);

    a_r2_idx_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tmr_q.idx));

    generate
        if (SAMP_NORM > 1 && SAMP_GREEN > 1) begin : g_gap
            a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/lbm_peak_hold.sv
module lbm_peak_hold #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic              first_i,
    input  logic              last_i,
    input  logic [LINE_W-1:0] sample_i,
    output logic [LINE_W-1:0] peak_o
);
    typedef struct packed {
        logic [LINE_W-1:0] run;
        logic [LINE_W-1:0] peak;
    } hold_t;

    hold_t hold_d, hold_q;
    logic [LINE_W-1:0] cand;

    always_comb begin
        if (first_i) cand = sample_i;
        else         cand = (sample_i > hold_q.run) ? sample_i : hold_q.run;
        hold_d = hold_q;
        if (stb_i) begin
            hold_d.run = cand;
            if (last_i) hold_d.peak = cand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign peak_o = hold_q.peak;

    a_r3_running_max_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !first_i) |=> hold_q.run >= $past(hold_q.run));

    a_r3_peak_only_at_group_end: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb_i && last_i) |=> $stable(hold_q.peak));

    a_r3_peak_not_below_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && last_i) |=> hold_q.peak >= $past(sample_i));
endmodule

// File: rtl/lbm_thresh_map.sv
module lbm_thresh_map #(
    parameter int LINE_W = 9,
    parameter int TH_W = 10,
    parameter int LINE_LO = 122,
    parameter int LINE_HI = 366,
    parameter int CODE_AT_LO = 825,
    parameter int CODE_AT_HI = 725
) (
    input  logic [LINE_W-1:0] peak_i,
    output logic [TH_W-1:0]   code_o
);
    localparam int SPAN = LINE_HI - LINE_LO;
    localparam int DROP = CODE_AT_LO - CODE_AT_HI;

    logic [31:0] pk, diff, prod, quo;

    always_comb begin
        pk   = 32'(peak_i);
        diff = pk - 32'(LINE_LO);
        prod = diff * 32'(DROP);
        quo  = prod / 32'(SPAN);
        if (pk <= 32'(LINE_LO))      code_o = TH_W'(CODE_AT_LO);
        else if (pk >= 32'(LINE_HI)) code_o = TH_W'(CODE_AT_HI);
        else                         code_o = TH_W'(32'(CODE_AT_LO) - quo);
    end
endmodule

// File: rtl/lbm_brown_fsm.sv
module lbm_brown_fsm
    import lbm_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int ON_V = 114,
    parameter int OFF_V = 102,
    parameter int DEB_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] peak_i,
    output logic              ok_o
);
    localparam int DW = width_for(DEB_CYC);
    localparam logic [DW-1:0] DEB_END = DW'(DEB_CYC - 1);

    typedef struct packed {
        logic          ok;
        logic [DW-1:0] deb;
    } bo_t;

    bo_t bo_d, bo_q;
    logic high, low;

    always_comb begin
        high = (32'(peak_i) >= 32'(ON_V));
        low  = (32'(peak_i) <  32'(OFF_V));
        bo_d = bo_q;
        if (!bo_q.ok) begin
            bo_d.deb = '0;
            if (high) bo_d.ok = 1'b1;
        end else if (low) begin
            if (bo_q.deb == DEB_END) begin
                bo_d.ok  = 1'b0;
                bo_d.deb = '0;
            end else begin
                bo_d.deb = bo_q.deb + 1'b1;
            end
        end else begin
            bo_d.deb = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bo_q <= '0;
        else        bo_q <= bo_d;
    end

    assign ok_o = bo_q.ok;

    a_r4_rise_needs_brownin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bo_q.ok) |-> 32'($past(peak_i)) >= 32'(ON_V));

    a_r6_fall_needs_brownout: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bo_q.ok) |-> 32'($past(peak_i)) < 32'(OFF_V));

    a_r5_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(peak_i) >= 32'(OFF_V) && 32'(peak_i) < 32'(ON_V)) |=> $stable(bo_q.ok));

    a_r6_debounce_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bo_q.deb <= DEB_END);
endmodule

// File: rtl/line_brownout_monitor.sv
module line_brownout_monitor #(
    parameter int LINE_W = 9,
    parameter int TH_W = 10,
    parameter int SAMP_NORM = 4,
    parameter int SAMP_GREEN = 12,
    parameter int NSAMP = 8,
    parameter int DEB_CYC = 5,
    parameter int BROWN_IN = 114,
    parameter int BROWN_OUT = 102,
    parameter int LINE_LO = 122,
    parameter int LINE_HI = 366,
    parameter int ILIM_AT_LO = 825,
    parameter int ILIM_AT_HI = 725,
    parameter int OCP_AT_LO = 480,
    parameter int OCP_AT_HI = 420
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_code,
    input  logic              green_mode,
    output logic              line_ok,
    output logic [TH_W-1:0]   ilim_code,
    output logic [TH_W-1:0]   ocp_code
);
    logic stb, grp_first, grp_last;
    logic [LINE_W-1:0] peak;

    lbm_sample_timer #(
        .SAMP_NORM(SAMP_NORM), .SAMP_GREEN(SAMP_GREEN), .NSAMP(NSAMP)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .slow_i(green_mode),
        .stb_o(stb), .first_o(grp_first), .last_o(grp_last)
    );

    lbm_peak_hold #(.LINE_W(LINE_W)) u_peak (
        .clk(clk), .rst_n(rst_n), .stb_i(stb), .first_i(grp_first),
        .last_i(grp_last), .sample_i(line_code), .peak_o(peak)
    );

    lbm_brown_fsm #(
        .LINE_W(LINE_W), .ON_V(BROWN_IN), .OFF_V(BROWN_OUT), .DEB_CYC(DEB_CYC)
    ) u_brown (
        .clk(clk), .rst_n(rst_n), .peak_i(peak), .ok_o(line_ok)
    );

    lbm_thresh_map #(
        .LINE_W(LINE_W), .TH_W(TH_W), .LINE_LO(LINE_LO), .LINE_HI(LINE_HI),
        .CODE_AT_LO(ILIM_AT_LO), .CODE_AT_HI(ILIM_AT_HI)
    ) u_ilim (
        .peak_i(peak), .code_o(ilim_code)
    );

    lbm_thresh_map #(
        .LINE_W(LINE_W), .TH_W(TH_W), .LINE_LO(LINE_LO), .LINE_HI(LINE_HI),
        .CODE_AT_LO(OCP_AT_LO), .CODE_AT_HI(OCP_AT_HI)
    ) u_ocp (
        .peak_i(peak), .code_o(ocp_code)
    );

    a_r9_ilim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ilim_code) <= 32'(ILIM_AT_LO) && 32'(ilim_code) >= 32'(ILIM_AT_HI));

    a_r9_ocp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ocp_code) <= 32'(OCP_AT_LO) && 32'(ocp_code) >= 32'(OCP_AT_HI));

    a_r7_ilim_falls_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        (peak > $past(peak)) |-> ilim_code <= $past(ilim_code));

    a_r8_ocp_falls_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        (peak > $past(peak)) |-> ocp_code <= $past(ocp_code));

    a_r7_codes_track_peak: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(peak) |-> ($stable(ilim_code) && $stable(ocp_code)));
endmodule

// File: tb/tb_line_brownout_monitor.sv
module tb_line_brownout_monitor;
    localparam int PER_N = 32;
    localparam int PER_G = 96;
    localparam int DEB = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] line_code = '0;
    logic green_mode = 1'b0;
    logic line_ok;
    logic [9:0] ilim_code, ocp_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    line_brownout_monitor dut (
        .clk(clk), .rst_n(rst_n), .line_code(line_code), .green_mode(green_mode),
        .line_ok(line_ok), .ilim_code(ilim_code), .ocp_code(ocp_code)
    );

    function automatic int exp_ilim(input int p);
        if (p <= 122) return 825;
        if (p >= 366) return 725;
        return 825 - ((p - 122) * 100) / 244;
    endfunction

    function automatic int exp_ocp(input int p);
        if (p <= 122) return 480;
        if (p >= 366) return 420;
        return 480 - ((p - 122) * 60) / 244;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int v);
        line_code = 9'(v);
        repeat ((green_mode ? PER_G : PER_N) * 3 + DEB + 4) @(negedge clk);
    endtask

    task automatic wait_ilim_change(input int old, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 4 * PER_G; i++) begin
            @(negedge clk);
            if (int'(ilim_code) != old) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 line_ok in reset", int'(line_ok), 0);
        chk("R1 ilim in reset", int'(ilim_code), 825);
        chk("R1 ocp in reset", int'(ocp_code), 480);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 line_ok after release", int'(line_ok), 0);
        chk("R1 ilim after release", int'(ilim_code), 825);
    endtask

    task automatic t_brownin_edge();
        settle(113);
        chk("R4 113 stays off", int'(line_ok), 0);
        chk("R9 ilim clamp 113", int'(ilim_code), 825);
        chk("R9 ocp clamp 113", int'(ocp_code), 480);
        settle(114);
        chk("R4 114 turns on", int'(line_ok), 1);
        settle(108);
        chk("R5 108 holds on", int'(line_ok), 1);
        settle(102);
        chk("R6 102 holds on", int'(line_ok), 1);
    endtask

    task automatic t_debounce();
        bit seen;
        settle(200);
        chk("R4 on at 200", int'(line_ok), 1);
        line_code = 9'd90;
        wait_ilim_change(exp_ilim(200), seen);
        chk("R6 drop published", int'(seen), 1);
        for (int k = 0; k <= DEB; k++) begin
            chk("R6 debounce timing", int'(line_ok), (k < DEB) ? 1 : 0);
            @(negedge clk);
        end
        settle(108);
        chk("R5 108 holds off", int'(line_ok), 0);
        line_code = 9'd200;
        wait_ilim_change(exp_ilim(90), seen);
        chk("R4 rise published", int'(seen), 1);
        chk("R4 still off at publish", int'(line_ok), 0);
        @(negedge clk);
        chk("R4 on one cycle later", int'(line_ok), 1);
    endtask

    task automatic t_thresholds();
        int pts[6] = '{122, 200, 244, 300, 366, 400};
        foreach (pts[i]) begin
            settle(pts[i]);
            chk((pts[i] >= 366) ? "R9 ilim high clamp" : "R7 ilim value",
                int'(ilim_code), exp_ilim(pts[i]));
            chk((pts[i] >= 366) ? "R9 ocp high clamp" : "R8 ocp value",
                int'(ocp_code), exp_ocp(pts[i]));
        end
    endtask

    task automatic t_group_max();
        bit hit;
        settle(130);
        chk("R7 ilim at 130", int'(ilim_code), exp_ilim(130));
        hit = 1'b0;
        line_code = 9'd250;
        repeat (8) @(negedge clk);
        line_code = 9'd130;
        for (int i = 0; i < 3 * PER_N; i++) begin
            @(negedge clk);
            if (int'(ilim_code) == exp_ilim(250)) hit = 1'b1;
        end
        chk("R3 short peak captured", int'(hit), 1);
        chk("R3 falling line followed", int'(ilim_code), exp_ilim(130));
        chk("R8 ocp back at 130", int'(ocp_code), exp_ocp(130));
    endtask

    task automatic t_cadence(input bit slow, input int per);
        int prev;
        int n;
        int t[3];
        green_mode = slow;
        settle(130);
        prev = int'(ilim_code);
        n = 0;
        for (int i = 0; i < 960 && n < 3; i++) begin
            @(negedge clk);
            if (int'(ilim_code) != prev) begin
                t[n] = i;
                n++;
                prev = int'(ilim_code);
            end
            line_code = 9'(130 + i / 4);
        end
        chk("R2 publish count", n, 3);
        if (n == 3) chk(slow ? "R2 slow group length" : "R2 fast group length", t[2] - t[1], per);
        green_mode = 1'b0;
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_brownin_edge();
        t_debounce();
        t_thresholds();
        t_group_max();
        t_cadence(1'b0, PER_N);
        t_cadence(1'b1, PER_G);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule